// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves one byte at a time between a parallel host side and a three-wire synchronous serial link made of a shift clock, a transmit data line and a receive data line. It runs in one of two clock modes. In clock-output mode it makes the shift clock itself from the system clock, using a half-period divider. In clock-input mode it follows a shift clock that another device drives. A select input then chooses whether received data is captured on the rising or the falling edge of that clock. In both modes, transmit data changes on the edge opposite the capture edge.

The host writes a byte with a load strobe. The byte goes out least significant bit first while the incoming line is shifted in, also least significant bit first. When the eighth capture edge arrives, the received byte is copied into a receive buffer. On that same cycle, a transmit interrupt pulse and a receive interrupt pulse are issued. If a new byte completes while the previous one is still unread, the buffer keeps the old byte and an overrun flag is raised. Reading the buffer clears both the buffer-full flag and the overrun flag.

Top module: `sio_shifter`

## Requirements
- R1: After reset, sclk_o is 1, txd is 1, busy is 0, and rx_full, overrun, tx_irq and rx_irq are all 0.
- R2: In clock-output mode (clk_in_mode = 0), a tx_load while idle starts a transfer. sclk_o stays high for half_div+1 cycles, then toggles every half_div+1 cycles. It returns high for good after the eighth rising edge, and busy then falls.
- R3: In clock-output mode, txd carries tx_data least significant bit first and changes only on a falling edge of sclk_o. rxd is sampled at each rising edge, and the eight samples form the received byte with the first sample in bit 0.
- R4: In clock-output mode, tx_irq and rx_irq are each high for exactly one cycle. That cycle is the one in which sclk_o rises for the eighth time, and rx_buf holds the new byte in that same cycle.
- R5: In clock-input mode with cap_fall = 0, rxd is captured on rising edges of sclk_i and txd changes after falling edges. tx_irq, rx_irq and the rx_buf update appear on the third clock edge after the final rising edge of sclk_i, because of the two-flop synchroniser and one register stage.
- R6: In clock-input mode with cap_fall = 1, the roles of the two edges are swapped. The interrupts and the buffer update follow the final falling edge of sclk_i with the same three-cycle latency.
- R7: If a byte completes while rx_full is 1 and rx_read is 0, then overrun becomes 1, rx_buf keeps its previous value, and rx_full stays 1.
- R8: A one-cycle rx_read pulse clears both rx_full and overrun.
- R9: A tx_load that arrives during a transfer is ignored. The byte already being shifted goes out unchanged.
- R10: sclk_oe is 1 in clock-output mode and 0 in clock-input mode.
- R11: In clock-input mode, a byte clocked in with no tx_load beforehand transmits all ones on txd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_in_mode | input | 1 | 1 = follow external sclk_i, 0 = generate sclk_o |
| cap_fall | input | 1 | Clock-input mode: 1 = capture on falling edge, 0 = on rising edge |
| half_div | input | DIV_W | Clock-output mode half period minus one, in system clocks |
| tx_load | input | 1 | Strobe that loads tx_data for the next byte |
| tx_data | input | DW | Byte to transmit |
| rx_read | input | 1 | Strobe that marks the receive buffer as read |
| sclk_o | output | 1 | Generated shift clock, idles high |
| sclk_oe | output | 1 | Output enable for the shift clock pin |
| sclk_i | input | 1 | Sensed shift clock pin |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| rx_buf | output | DW | Receive buffer |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| overrun | output | 1 | A byte was lost because the buffer was full |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| busy | output | 1 | A byte is in progress |

## Verification
The assertions assume three things. The clock mode and the edge select stay fixed while a byte is in progress. half_div is at least 2, so a value driven on rxd at a falling edge has passed the two-flop synchroniser before the next rising edge. The external shift clock holds each level for several system clocks. The bench meets these assumptions directly. It uses divider values from 2 to 5, holds each external clock level for six cycles, and changes mode or idle level only while in clock-output mode with no transfer running. It also moves rxd only together with the launch edge.

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_in_mode,
  input  logic             cap_fall,
  input  logic [DIV_W-1:0] half_div,
  input  logic             tx_load,
  input  logic [DW-1:0]    tx_data,
  input  logic             rx_read,
  output logic             sclk_o,
  output logic             sclk_oe,
  input  logic             sclk_i,
  output logic             txd,
  input  logic             rxd,
  output logic [DW-1:0]    rx_buf,
  output logic             rx_full,
  output logic             overrun,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             busy
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [2:0]       sck_s;
  logic [1:0]       rxd_s;
  logic [1:0]       warm;
  logic             sclk_r, run;
  logic [DIV_W-1:0] dcnt;
  logic [CW-1:0]    bitcnt;
  logic [DW-1:0]    tx_sr, rx_sr;

  wire tick     = run && (dcnt == half_div);
  wire o_rise   = tick && !sclk_r;
  wire o_fall   = tick && sclk_r;
  wire ready    = (warm == 2'b11);
  wire e_rise   = ready && sck_s[1] && !sck_s[2];
  wire e_fall   = ready && !sck_s[1] && sck_s[2];
  wire cap      = clk_in_mode ? (cap_fall ? e_fall : e_rise) : o_rise;
  wire lau      = clk_in_mode ? (cap_fall ? e_rise : e_fall) : o_fall;
  wire last     = cap && (bitcnt == CW'(DW - 1));
  wire can_load = tx_load && !run && (bitcnt == '0);
  wire [DW-1:0] rx_next = {rxd_s[1], rx_sr[DW-1:1]};

  assign sclk_o  = sclk_r;
  assign sclk_oe = !clk_in_mode;
  assign txd     = tx_sr[0];
  assign busy    = run || (bitcnt != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0;
      rxd_s <= '1;
      warm  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sclk_i};
      rxd_s <= {rxd_s[0], rxd};
      if (!ready) warm <= warm + 2'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run    <= 1'b0;
      sclk_r <= 1'b1;
      dcnt   <= '0;
    end else if (can_load && !clk_in_mode) begin
      run  <= 1'b1;
      dcnt <= '0;
    end else if (run) begin
      if (tick) begin
        dcnt   <= '0;
        sclk_r <= !sclk_r;
        if (last) run <= 1'b0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sr  <= '1;
      rx_sr  <= '0;
      bitcnt <= '0;
    end else begin
      if (last)
        tx_sr <= '1;
      else if (can_load)
        tx_sr <= tx_data;
      else if (lau && bitcnt != '0)
        tx_sr <= {1'b1, tx_sr[DW-1:1]};
      if (cap) begin
        rx_sr  <= rx_next;
        bitcnt <= last ? '0 : bitcnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
      tx_irq  <= 1'b0;
      rx_irq  <= 1'b0;
    end else begin
      tx_irq <= last;
      rx_irq <= last;
      if (last) begin
        if (!rx_full || rx_read) begin
          rx_buf  <= rx_next;
          rx_full <= 1'b1;
          overrun <= 1'b0;
        end else begin
          overrun <= 1'b1;
        end
      end else if (rx_read) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
      end
    end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_in_mode && !run) |-> sclk_o);

  // R3
  txd_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_in_mode && run && $past(run) && !$stable(txd)) |-> $fell(sclk_o));

  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  // R4
  rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);

  // R7
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $stable(rx_buf));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read && !last) |=> (!rx_full && !overrun));
endmodule

// File: tb/test_sio_shifter.sv
`timescale 1ns/1ps
module test_sio_shifter;
  logic clk = 0, rst_n = 0;
  logic clk_in_mode = 0, cap_fall = 0, tx_load = 0, rx_read = 0;
  logic sclk_i = 1, rxd = 1;
  logic [7:0] half_div = 8'd2, tx_data = '0;
  logic sclk_o, sclk_oe, txd, rx_full, overrun, tx_irq, rx_irq, busy;
  logic [7:0] rx_buf;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sio_shifter i_sio_shifter (.clk, .rst_n, .clk_in_mode, .cap_fall, .half_div,
    .tx_load, .tx_data, .rx_read, .sclk_o, .sclk_oe, .sclk_i, .txd, .rxd,
    .rx_buf, .rx_full, .overrun, .tx_irq, .rx_irq, .busy);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read();
    @(negedge clk) rx_read = 1;
    @(negedge clk) rx_read = 0;
    chk(!rx_full && !overrun, "R8 read clears flags", {rx_full, overrun}, 0);
  endtask

  task automatic xfer_out(input logic [7:0] tx, input logic [7:0] rx, input logic [7:0] exp_buf,
                          input int div, input bit mid_load);
    logic [7:0] got = '0;
    logic prev, prev_txd;
    int nrise = 0, nfall = 0, cyc = 0, half = -1;
    clk_in_mode = 0;
    half_div = div[7:0];
    @(negedge clk) begin tx_load = 1; tx_data = tx; end
    @(negedge clk) tx_load = 0;
    chk(busy, "R2 busy after load", busy, 1);
    prev = sclk_o;
    prev_txd = txd;
    while (nrise < 8 && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (prev && !sclk_o) begin
        rxd = rx[nfall];
        nfall++;
        if (nfall == 1) half = 0;
        if (mid_load && nfall == 3) begin tx_load = 1; tx_data = ~tx; end
      end else if (half >= 0) half++;
      if (tx_load && nfall == 3 && !(prev && !sclk_o)) tx_load = 0;
      if (!prev && sclk_o) begin
        got[nrise] = prev_txd;
        nrise++;
        if (nrise == 1) chk(half == div + 1, "R2 half period", half, div + 1);
        if (nrise == 8) begin
          chk(tx_irq && rx_irq, "R4 irq at last rising edge", {tx_irq, rx_irq}, 2'b11);
          chk(rx_buf == exp_buf, "R3 received byte", rx_buf, exp_buf);
        end else
          chk(!tx_irq, "R4 no early irq", tx_irq, 0);
      end
      prev = sclk_o;
      prev_txd = txd;
    end
    tx_load = 0;
    chk(got == tx, mid_load ? "R9 load during transfer ignored" : "R3 transmitted byte", got, tx);
    @(negedge clk);
    chk(!tx_irq && !rx_irq, "R4 irq one cycle", {tx_irq, rx_irq}, 0);
    chk(!busy && sclk_o, "R2 idle after byte", {busy, sclk_o}, 2'b01);
  endtask

  task automatic set_idle(input bit fall);
    clk_in_mode = 0;
    @(negedge clk) sclk_i = fall ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    cap_fall = fall;
    clk_in_mode = 1;
    @(negedge clk);
  endtask

  task automatic xfer_in(input logic [7:0] tx, input logic [7:0] rx, input bit fall, input bit load);
    logic [7:0] got = '0;
    logic idle;
    string rq;
    rq = fall ? "R6" : "R5";
    idle = fall ? 1'b0 : 1'b1;
    set_idle(fall);
    if (load) begin
      @(negedge clk) begin tx_load = 1; tx_data = tx; end
      @(negedge clk) tx_load = 0;
    end
    for (int b = 0; b < 8; b++) begin
      @(negedge clk) begin sclk_i = ~idle; rxd = rx[b]; end
      repeat (6) @(negedge clk);
      got[b] = txd;
      sclk_i = idle;
      if (b < 7) repeat (6) @(negedge clk);
    end
    @(negedge clk);
    chk(!tx_irq, {rq, " irq not before sync delay"}, tx_irq, 0);
    @(negedge clk);
    chk(!tx_irq, {rq, " irq not before sync delay"}, tx_irq, 0);
    @(negedge clk);
    chk(tx_irq && rx_irq, {rq, " irq after final edge"}, {tx_irq, rx_irq}, 2'b11);
    chk(rx_buf == rx, {rq, " received byte"}, rx_buf, rx);
    chk(got == (load ? tx : 8'hFF), load ? {rq, " transmitted byte"} : "R11 unloaded sends ones",
        got, load ? tx : 8'hFF);
    @(negedge clk);
    chk(!tx_irq, {rq, " irq one cycle"}, tx_irq, 0);
  endtask

  typedef struct packed {
    logic       inm;
    logic       fall;
    logic [7:0] div;
    logic [7:0] tx;
    logic [7:0] rx;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 1'b0, 8'd2, 8'hA5, 8'h3C},
    '{1'b0, 1'b0, 8'd5, 8'h01, 8'h80},
    '{1'b0, 1'b0, 8'd3, 8'hFF, 8'h00},
    '{1'b1, 1'b0, 8'd0, 8'h5A, 8'hC6},
    '{1'b1, 1'b1, 8'd0, 8'h80, 8'h01},
    '{1'b1, 1'b0, 8'd0, 8'h00, 8'hFF}
  };

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk_o && txd && !busy, "R1 reset lines", {sclk_o, txd, busy}, 3'b110);
    chk(!rx_full && !overrun && !tx_irq && !rx_irq, "R1 reset flags",
        {rx_full, overrun, tx_irq, rx_irq}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(sclk_oe, "R10 oe in output mode", sclk_oe, 1);
    clk_in_mode = 1;
    @(negedge clk);
    chk(!sclk_oe, "R10 oe in input mode", sclk_oe, 0);
    chk(!busy, "R1 stays idle", busy, 0);
    clk_in_mode = 0;

    foreach (VEC[i]) begin
      if (VEC[i].inm) xfer_in(VEC[i].tx, VEC[i].rx, VEC[i].fall, 1'b1);
      else            xfer_out(VEC[i].tx, VEC[i].rx, VEC[i].rx, int'(VEC[i].div), 1'b0);
      do_read();
    end

    xfer_in(8'h00, 8'h96, 1'b1, 1'b0);
    do_read();

    xfer_out(8'h81, 8'h3C, 8'h3C, 3, 1'b1);
    xfer_out(8'h42, 8'hC3, 8'h3C, 2, 1'b0);
    chk(overrun && rx_full, "R7 overrun raised", {overrun, rx_full}, 2'b11);
    chk(rx_buf == 8'h3C, "R7 buffer kept", rx_buf, 8'h3C);
    do_read();
    xfer_out(8'h24, 8'h99, 8'h99, 4, 1'b0);
    chk(rx_full && !overrun, "R8 new byte after read", {rx_full, overrun}, 2'b10);
    do_read();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule